// File: doc/BRIEF.md
# Circular DMA channel with midpoint and end-of-buffer interrupts

This block is one data-movement channel that copies words without processor help. It can copy from a peripheral into memory, from memory out to a peripheral, or from one memory region to another. Software programs a start source address, a start destination address, a word count, the copy direction, two address-step bits, a burst length and a circular-mode bit through a small register port. Nothing moves until software then sets the enable bit.

A peripheral asks for service over a valid/ready request handshake. Each accepted request moves one burst of words. A memory-to-memory copy starts its bursts on its own, without waiting for a request. Every word takes two cycles. In the first cycle the channel reads the source, and the data returns one cycle later. In the second cycle the channel writes that data to the destination.

The channel raises a sticky flag when half of the count has been moved and another when all of it has. Each flag has its own interrupt enable. In circular mode the channel reloads its start addresses and count at the end of the buffer and keeps running. Software can therefore work on one half of a buffer while the channel fills the other half.

Top module: `dma_circ_top`

## Requirements
- R1: After reset every register reads zero, `irq` is low and no strobe is active. While the enable bit is clear, no word moves, whatever has been programmed.
- R2: Peripheral-to-memory copy (direction code 0). The channel pulses `per_rd` in one cycle. In the next cycle it pulses `mem_we` with `mem_wdata` equal to the `per_rdata` that the peripheral returned.
- R3: Memory-to-peripheral copy (direction code 1). The channel pulses `mem_re`. In the next cycle it pulses `per_wr` with `per_wdata` equal to the returned `mem_rdata`.
- R4: Memory-to-memory copy (direction code 2 or 3) runs without any request, and `per_req_ready` stays low throughout. At most one of the four strobes is active in any cycle.
- R5: Control bit 3 makes the memory-side address step by one word after each word, and bit 4 does the same for the peripheral-side address. When a bit is clear, that address stays at its start value.
- R6: Each accepted request (`per_req_valid` and `per_req_ready` both high) moves a burst of (control bits 9:8) + 1 words. A burst is cut short only at the end of the count. `per_req_ready` is high only while the channel is enabled and between bursts, so a request held during a burst waits.
- R7: Status bit 0 (half flag) is set when floor(N/2) words of a count N have been moved in a pass. It is never set for N = 1.
- R8: Status bit 1 (complete flag) is set when the N-th word is written. With control bit 5 clear, the channel then clears its enable bit, the remaining count reads 0, and the channel stops.
- R9: With control bit 5 set, the channel reloads its start addresses and count after the N-th word. It keeps its enable bit set and runs further passes without software.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. `irq` = (half flag AND control bit 6) OR (complete flag AND control bit 7).
- R11: Setting enable while the count register is 0 sets status bit 2 (error flag) and leaves the channel disabled, with no word moved.
- R12: The remaining count (register 4) is readable while the channel runs and drops by one per word. While the channel is enabled or mid-burst, writes to the control (0), source (1), destination (2) and count (3) registers are ignored. The one exception is a control write with bit 0 clear: it clears the enable bit, and the channel stops after its current burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 control, 1 source, 2 destination, 3 count, 4 remaining, 5 status) |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational on reg_addr) |
| irq | output | 1 | Interrupt, per R10 |
| per_req_valid | input | 1 | Peripheral asks for a burst |
| per_req_ready | output | 1 | Channel accepts the request |
| per_addr | output | AW | Peripheral-side word address |
| per_rd | output | 1 | Peripheral read strobe; data expected on per_rdata next cycle |
| per_wr | output | 1 | Peripheral write strobe |
| per_wdata | output | DW | Peripheral write data |
| per_rdata | input | DW | Peripheral read data |
| mem_addr | output | AW | Memory word address |
| mem_re | output | 1 | Memory read strobe; data expected on mem_rdata next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |

## Verification
The bench builds the block with its default parameters: 16-bit addresses and counts, 32-bit words and a 2-bit burst field. The 2-bit burst field makes bursts of 1 to 4 words reachable, including bursts cut short by the end of the count. Because the counts programmed are short (1 to 8 words), a full pass, the midpoint flag for odd and even counts, the count of 1 with no midpoint, and several circular wraps each take only a few dozen cycles. This keeps every direction and address-step combination within reach in one short run.

// File: rtl/dma_circ_pkg.sv
// Shared encodings for the circular DMA channel: register indices,
// direction codes, sequencer states and the control-field bundle.
package dma_circ_pkg;

    localparam logic [2:0] REG_CTRL   = 3'd0;
    localparam logic [2:0] REG_SRC    = 3'd1;
    localparam logic [2:0] REG_DST    = 3'd2;
    localparam logic [2:0] REG_COUNT  = 3'd3;
    localparam logic [2:0] REG_REMAIN = 3'd4;
    localparam logic [2:0] REG_STAT   = 3'd5;

    typedef enum logic [1:0] {
        DIR_P2M  = 2'd0,
        DIR_M2P  = 2'd1,
        DIR_M2M  = 2'd2,
        DIR_M2MX = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } xfer_st_e;

    typedef struct packed {
        logic tc_ie;
        logic ht_ie;
        logic circ;
        logic per_inc;
        logic mem_inc;
        dir_e dir;
    } ctrl_t;

endpackage

// File: rtl/dma_circ_regs.sv
// Register file of the channel: configuration, enable, sticky flags
// and the interrupt output. Assumes a single-cycle write strobe and a
// combinational read. Configuration is locked while the channel is
// enabled or a burst is still draining.
module dma_circ_regs
    import dma_circ_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 32,
    parameter int CW      = 16,
    parameter int BURST_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    input  logic               busy,
    input  logic [CW-1:0]      remain,
    input  logic               ev_ht,
    input  logic               ev_tc,
    input  logic               ev_done,
    output ctrl_t              ctrl,
    output logic [BURST_W-1:0] burst,
    output logic [AW-1:0]      src_base,
    output logic [AW-1:0]      dst_base,
    output logic [CW-1:0]      count,
    output logic               en,
    output logic               start,
    output logic               irq
);

    logic ht_flag, tc_flag, err_flag;
    logic wr_ctrl, wr_stat, cfg_open, bad_start;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign wr_ctrl   = reg_we && (reg_addr == REG_CTRL);
    assign wr_stat   = reg_we && (reg_addr == REG_STAT);
    assign cfg_open  = !en && !busy;
    assign start     = wr_ctrl && reg_wdata[0] && cfg_open && (count != '0);
    assign bad_start = wr_ctrl && reg_wdata[0] && cfg_open && (count == '0);
    assign irq       = (ht_flag && ctrl.ht_ie) || (tc_flag && ctrl.tc_ie);

    // Configuration capture, enable control and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl     <= '0;
            burst    <= '0;
            src_base <= '0;
            dst_base <= '0;
            count    <= '0;
            en       <= 1'b0;
            ht_flag  <= 1'b0;
            tc_flag  <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            if (cfg_open && reg_we) begin
                unique case (reg_addr)
                    REG_CTRL: begin
                        ctrl.dir     <= dir_e'(reg_wdata[2:1]);
                        ctrl.mem_inc <= reg_wdata[3];
                        ctrl.per_inc <= reg_wdata[4];
                        ctrl.circ    <= reg_wdata[5];
                        ctrl.ht_ie   <= reg_wdata[6];
                        ctrl.tc_ie   <= reg_wdata[7];
                        burst        <= reg_wdata[8 +: BURST_W];
                    end
                    REG_SRC:   src_base <= reg_wdata[AW-1:0];
                    REG_DST:   dst_base <= reg_wdata[AW-1:0];
                    REG_COUNT: count    <= reg_wdata[CW-1:0];
                    default: ;
                endcase
            end
            if (start)                         en <= 1'b1;
            else if (wr_ctrl && !reg_wdata[0]) en <= 1'b0;
            else if (ev_done)                  en <= 1'b0;
            ht_flag  <= ev_ht || (ht_flag && !(wr_stat && reg_wdata[0]));
            tc_flag  <= ev_tc || (tc_flag && !(wr_stat && reg_wdata[1]));
            err_flag <= bad_start || (err_flag && !(wr_stat && reg_wdata[2]));
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_CTRL: begin
                reg_rdata[0]           = en;
                reg_rdata[2:1]         = ctrl.dir;
                reg_rdata[3]           = ctrl.mem_inc;
                reg_rdata[4]           = ctrl.per_inc;
                reg_rdata[5]           = ctrl.circ;
                reg_rdata[6]           = ctrl.ht_ie;
                reg_rdata[7]           = ctrl.tc_ie;
                reg_rdata[8 +: BURST_W] = burst;
            end
            REG_SRC:    reg_rdata = DW'(src_base);
            REG_DST:    reg_rdata = DW'(dst_base);
            REG_COUNT:  reg_rdata = DW'(count);
            REG_REMAIN: reg_rdata = DW'(remain);
            REG_STAT:   reg_rdata[2:0] = {err_flag, tc_flag, ht_flag};
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_circ_xfer.sv
// Word sequencer: accepts peripheral requests, runs bursts of
// read-then-write beats, steps addresses, counts down and emits the
// half, complete and stop events. Assumes one-cycle read latency on
// both the memory and the peripheral data ports.
module dma_circ_xfer
    import dma_circ_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 32,
    parameter int CW      = 16,
    parameter int BURST_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               start,
    input  dir_e               dir,
    input  logic               mem_inc,
    input  logic               per_inc,
    input  logic               circ,
    input  logic [BURST_W-1:0] burst,
    input  logic [AW-1:0]      src_base,
    input  logic [AW-1:0]      dst_base,
    input  logic [CW-1:0]      count,
    input  logic               per_req_valid,
    output logic               per_req_ready,
    output logic               busy,
    output logic [CW-1:0]      remain,
    output logic               ev_ht,
    output logic               ev_tc,
    output logic               ev_done,
    output logic [AW-1:0]      mem_addr,
    output logic               mem_re,
    output logic               mem_we,
    output logic [DW-1:0]      mem_wdata,
    input  logic [DW-1:0]      mem_rdata,
    output logic [AW-1:0]      per_addr,
    output logic               per_rd,
    output logic               per_wr,
    output logic [DW-1:0]      per_wdata,
    input  logic [DW-1:0]      per_rdata
);

    xfer_st_e           state;
    logic [AW-1:0]      cur_src, cur_dst;
    logic [BURST_W-1:0] beat;
    logic [CW-1:0]      half, ht_mark;
    logic               src_mem, dst_mem, src_step, dst_step;
    logic               is_m2m, go, last_word, last_beat;
    logic [DW-1:0]      word;

    assign src_mem   = (dir != DIR_P2M);
    assign dst_mem   = (dir != DIR_M2P);
    assign is_m2m    = dir[1];
    assign src_step  = src_mem ? mem_inc : per_inc;
    assign dst_step  = dst_mem ? mem_inc : per_inc;
    assign half      = count >> 1;
    assign ht_mark   = count - half;
    assign last_word = (remain == CW'(1));
    assign last_beat = (beat == burst);
    assign busy      = (state != ST_IDLE);

    assign per_req_ready = (state == ST_IDLE) && en && !is_m2m && per_req_valid;
    assign go            = (state == ST_IDLE) && en && (is_m2m || per_req_valid);

    assign ev_tc   = (state == ST_WR) && last_word;
    assign ev_ht   = (state == ST_WR) && (half != '0) && ((remain - CW'(1)) == ht_mark);
    assign ev_done = ev_tc && !circ;

    assign mem_re    = (state == ST_RD) && src_mem;
    assign per_rd    = (state == ST_RD) && !src_mem;
    assign mem_we    = (state == ST_WR) && dst_mem;
    assign per_wr    = (state == ST_WR) && !dst_mem;
    assign mem_addr  = (state == ST_WR) ? cur_dst : cur_src;
    assign per_addr  = src_mem ? cur_dst : cur_src;
    assign word      = src_mem ? mem_rdata : per_rdata;
    assign mem_wdata = word;
    assign per_wdata = word;

    // Burst sequencing, address stepping and count-down with reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_src <= '0;
            cur_dst <= '0;
            remain  <= '0;
            beat    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cur_src <= src_base;
                        cur_dst <= dst_base;
                        remain  <= count;
                    end else if (go) begin
                        state <= ST_RD;
                        beat  <= '0;
                    end
                end
                ST_RD: state <= ST_WR;
                ST_WR: begin
                    beat <= beat + 1'b1;
                    if (last_word) begin
                        state <= ST_IDLE;
                        if (circ) begin
                            cur_src <= src_base;
                            cur_dst <= dst_base;
                            remain  <= count;
                        end else begin
                            remain <= '0;
                        end
                    end else begin
                        remain  <= remain - 1'b1;
                        cur_src <= cur_src + AW'(src_step);
                        cur_dst <= cur_dst + AW'(dst_step);
                        state   <= last_beat ? ST_IDLE : ST_RD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma_circ_top.sv
// Top of the circular DMA channel: joins the register file and the
// word sequencer. Assumes the caller's memory and peripheral return
// read data one cycle after the read strobe.
module dma_circ_top
    import dma_circ_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 32,
    parameter int CW      = 16,
    parameter int BURST_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    input  logic          per_req_valid,
    output logic          per_req_ready,
    output logic [AW-1:0] per_addr,
    output logic          per_rd,
    output logic          per_wr,
    output logic [DW-1:0] per_wdata,
    input  logic [DW-1:0] per_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_re,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);

    ctrl_t              ctrl;
    logic [BURST_W-1:0] burst;
    logic [AW-1:0]      src_base, dst_base;
    logic [CW-1:0]      count, remain;
    logic               en, start, busy, ev_ht, ev_tc, ev_done;

    dma_circ_regs #(.AW(AW), .DW(DW), .CW(CW), .BURST_W(BURST_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .busy(busy), .remain(remain),
        .ev_ht(ev_ht), .ev_tc(ev_tc), .ev_done(ev_done),
        .ctrl(ctrl), .burst(burst), .src_base(src_base), .dst_base(dst_base),
        .count(count), .en(en), .start(start), .irq(irq)
    );

    dma_circ_xfer #(.AW(AW), .DW(DW), .CW(CW), .BURST_W(BURST_W)) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .en(en), .start(start),
        .dir(ctrl.dir), .mem_inc(ctrl.mem_inc), .per_inc(ctrl.per_inc),
        .circ(ctrl.circ), .burst(burst),
        .src_base(src_base), .dst_base(dst_base), .count(count),
        .per_req_valid(per_req_valid), .per_req_ready(per_req_ready),
        .busy(busy), .remain(remain),
        .ev_ht(ev_ht), .ev_tc(ev_tc), .ev_done(ev_done),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .per_addr(per_addr), .per_rd(per_rd), .per_wr(per_wr),
        .per_wdata(per_wdata), .per_rdata(per_rdata)
    );

endmodule

// File: rtl/dma_circ_chk.sv
// Protocol checker for the circular DMA channel, bound to the top.
// Assumes nothing beyond the top's ports and its internal enable,
// busy, count and remaining-count state.
module dma_circ_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          busy,
    input logic          circ,
    input logic          m2m,
    input logic [CW-1:0] count,
    input logic [CW-1:0] remain,
    input logic          reg_we,
    input logic [2:0]    reg_addr,
    input logic          wr_en_bit,
    input logic          per_req_valid,
    input logic          per_req_ready,
    input logic          mem_re,
    input logic          mem_we,
    input logic          per_rd,
    input logic          per_wr
);

    p_read_then_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || per_rd) |=> (mem_we || per_wr));

    p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_re, mem_we, per_rd, per_wr}));

    p_copy_no_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m2m |-> !per_req_ready);

    p_grant_between_bursts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        per_req_ready |-> (per_req_valid && en && !busy));

    p_grant_opens_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        per_req_ready |=> (mem_re || per_rd));

    p_oneshot_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || per_wr) && remain == CW'(1) && !circ) |=> (!en && remain == '0));

    p_wrap_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || per_wr) && remain == CW'(1) && circ) |=> (remain == count));

    p_zero_count_refused_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd0 && wr_en_bit && !en && !busy && count == '0) |=> !en);

    p_count_steps_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || per_wr) && remain > CW'(1)) |=> (remain == $past(remain) - CW'(1)));

endmodule

bind dma_circ_top dma_circ_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .en(en), .busy(busy), .circ(ctrl.circ), .m2m(ctrl.dir[1]),
    .count(count), .remain(remain),
    .reg_we(reg_we), .reg_addr(reg_addr), .wr_en_bit(reg_wdata[0]),
    .per_req_valid(per_req_valid), .per_req_ready(per_req_ready),
    .mem_re(mem_re), .mem_we(mem_we), .per_rd(per_rd), .per_wr(per_wr)
);

// File: tb/test_dma_circ_top.sv
`timescale 1ns/1ps
module test_dma_circ_top;
    import dma_circ_pkg::*;

    localparam int AW = 16, DW = 32, CW = 16, BW = 2;
    localparam int SRC = 16, DST = 64;

    // Vector: [21:20] dir, [19] mem_inc, [18] per_inc, [17:16] burst-1,
    //         [15:8] count, [7:0] expected number of granted requests
    localparam logic [21:0] VEC [6] = '{
        {2'd2, 1'b1, 1'b1, 2'd3, 8'd8, 8'd0},
        {2'd0, 1'b1, 1'b0, 2'd1, 8'd5, 8'd3},
        {2'd1, 1'b1, 1'b1, 2'd0, 8'd4, 8'd4},
        {2'd0, 1'b0, 1'b1, 2'd3, 8'd6, 8'd2},
        {2'd2, 1'b0, 1'b0, 2'd0, 8'd3, 8'd0},
        {2'd1, 1'b0, 1'b0, 2'd2, 8'd7, 8'd3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq;
    logic          per_req_valid = 1'b0;
    logic          per_req_ready;
    logic [AW-1:0] per_addr, mem_addr;
    logic          per_rd, per_wr, mem_re, mem_we;
    logic [DW-1:0] per_wdata, mem_wdata;
    logic [DW-1:0] per_rdata = '0;
    logic [DW-1:0] mem_rdata = '0;

    logic [DW-1:0] mem [128];
    logic [DW-1:0] plog_d [64];
    logic [AW-1:0] plog_a [64];
    int per_cnt = 0, per_wcnt = 0, grants = 0, we_cnt = 0, strobe_cnt = 0;
    logic [AW-1:0] last_raddr = '0;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_circ_top #(.AW(AW), .DW(DW), .CW(CW), .BURST_W(BW)) i_dma_circ_top (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq),
        .per_req_valid(per_req_valid), .per_req_ready(per_req_ready),
        .per_addr(per_addr), .per_rd(per_rd), .per_wr(per_wr),
        .per_wdata(per_wdata), .per_rdata(per_rdata),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory and peripheral models, one-cycle read latency, plus monitors.
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr[6:0]];
        if (mem_we) mem[mem_addr[6:0]] <= mem_wdata;
        if (per_rd) begin
            per_rdata  <= 32'h5000_0000 + per_cnt;
            per_cnt    <= per_cnt + 1;
            last_raddr <= per_addr;
        end
        if (per_wr) begin
            plog_d[per_wcnt[5:0]] <= per_wdata;
            plog_a[per_wcnt[5:0]] <= per_addr;
            per_wcnt <= per_wcnt + 1;
        end
        if (per_req_valid && per_req_ready) grants <= grants + 1;
        if (mem_we) we_cnt <= we_cnt + 1;
        if (mem_re || mem_we || per_rd || per_wr) strobe_cnt <= strobe_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_flag(input int bitn, output bit seen);
        logic [31:0] d;
        seen = 1'b0;
        for (int c = 0; c < 3000 && !seen; c++) begin
            rd(REG_STAT, d);
            if (d[bitn]) seen = 1'b1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, ctl;
        logic [21:0] e;
        int n, k0, w0, g0, s0;
        bit seen;

        for (int i = 0; i < 128; i++) mem[i] <= (i >= SRC && i < SRC + 16) ? 32'h1000_0000 + i * 7 : '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(REG_CTRL, d);   chk("R1 ctrl after reset", d, 0);
        rd(REG_REMAIN, d); chk("R1 remain after reset", d, 0);
        rd(REG_STAT, d);   chk("R1 status after reset", d, 0);
        chk("R1 irq after reset", {31'd0, irq}, 0);

        // R1: programmed but not enabled
        wr(REG_SRC, SRC); wr(REG_DST, DST); wr(REG_COUNT, 4);
        s0 = strobe_cnt;
        wr(REG_CTRL, 32'h0000_0008 | (2 << 1));
        repeat (20) @(negedge clk);
        chk("R1 no strobes while disabled", strobe_cnt - s0, 0);

        // R11: zero count refused
        wr(REG_COUNT, 0);
        wr(REG_CTRL, 32'h0000_0009 | (2 << 1));
        repeat (10) @(negedge clk);
        rd(REG_STAT, d); chk("R11 error flag", d, 4);
        rd(REG_CTRL, d); chk("R11 stays disabled", {31'd0, d[0]}, 0);
        chk("R11 nothing moved", strobe_cnt - s0, 0);
        wr(REG_STAT, 4);
        rd(REG_STAT, d); chk("R10 error cleared by write one", d, 0);

        // Vector table walk
        for (int v = 0; v < 6; v++) begin
            e = VEC[v];
            n = int'(e[15:8]);
            for (int i = DST; i < DST + 16; i++) mem[i] <= '0;
            k0 = per_cnt; w0 = per_wcnt; g0 = grants;
            ctl = 32'h1 | (32'(e[21:20]) << 1) | (32'(e[19]) << 3) | (32'(e[18]) << 4)
                | 32'h40 | 32'h80 | (32'(e[17:16]) << 8);
            wr(REG_SRC, SRC); wr(REG_DST, DST); wr(REG_COUNT, n);
            per_req_valid = 1'b1;
            wr(REG_CTRL, ctl);
            wait_flag(1, seen);
            per_req_valid = 1'b0;
            repeat (6) @(negedge clk);
            chk($sformatf("R8 vec%0d completion seen", v), {31'd0, seen}, 1);
            rd(REG_STAT, d);   chk($sformatf("R7 R8 vec%0d half and complete flags", v), d, 3);
            chk($sformatf("R10 vec%0d irq", v), {31'd0, irq}, 1);
            rd(REG_CTRL, d);   chk($sformatf("R8 vec%0d enable cleared", v), {31'd0, d[0]}, 0);
            rd(REG_REMAIN, d); chk($sformatf("R8 vec%0d remain zero", v), d, 0);
            chk($sformatf("R6 R4 vec%0d grants", v), grants - g0, 32'(e[7:0]));
            case (e[21:20])
                2'd0: begin
                    if (e[19]) begin
                        for (int i = 0; i < n; i++)
                            chk($sformatf("R2 vec%0d word %0d", v, i), mem[DST + i], 32'h5000_0000 + k0 + i);
                    end else begin
                        chk($sformatf("R2 R5 vec%0d fixed dst", v), mem[DST], 32'h5000_0000 + k0 + n - 1);
                        chk($sformatf("R5 vec%0d dst+1 untouched", v), mem[DST + 1], 0);
                    end
                    chk($sformatf("R5 vec%0d last peripheral addr", v), 32'(last_raddr),
                        e[18] ? SRC + n - 1 : SRC);
                end
                2'd1: begin
                    chk($sformatf("R3 vec%0d peripheral writes", v), per_wcnt - w0, n);
                    for (int i = 0; i < n; i++) begin
                        chk($sformatf("R3 vec%0d data %0d", v, i), plog_d[(w0 + i) % 64],
                            mem[e[19] ? SRC + i : SRC]);
                        chk($sformatf("R5 vec%0d addr %0d", v, i), 32'(plog_a[(w0 + i) % 64]),
                            e[18] ? DST + i : DST);
                    end
                end
                default: begin
                    if (e[19]) begin
                        for (int i = 0; i < n; i++)
                            chk($sformatf("R4 vec%0d copy %0d", v, i), mem[DST + i], mem[SRC + i]);
                    end else begin
                        chk($sformatf("R4 R5 vec%0d fixed copy", v), mem[DST], mem[SRC]);
                        chk($sformatf("R5 vec%0d dst+1 untouched", v), mem[DST + 1], 0);
                    end
                end
            endcase
            wr(REG_STAT, 3);
            rd(REG_STAT, d); chk($sformatf("R10 vec%0d flags cleared", v), d, 0);
        end

        // R7: odd count 5, half flag after 2 words; R10 masking by enables
        wr(REG_COUNT, 5);
        wr(REG_CTRL, 32'h1 | (2 << 1) | 32'h8 | 32'h40);
        wait_flag(0, seen);
        rd(REG_REMAIN, d); chk("R7 remain at half flag (count 5)", d, 3);
        chk("R10 irq from half flag", {31'd0, irq}, 1);
        wait_flag(1, seen);
        wr(REG_STAT, 1);
        rd(REG_STAT, d); chk("R10 write one clears only half flag", d, 2);
        chk("R10 complete flag masked", {31'd0, irq}, 0);
        wr(REG_STAT, 2);

        // R7: count 1 gives no half flag
        wr(REG_COUNT, 1);
        wr(REG_CTRL, 32'h1 | (2 << 1) | 32'h8 | 32'h40);
        wait_flag(1, seen);
        rd(REG_STAT, d); chk("R7 count 1 has no half flag", d, 2);
        wr(REG_STAT, 3);

        // R9 / R12: circular run
        wr(REG_COUNT, 4);
        wr(REG_CTRL, 32'h1 | (2 << 1) | 32'h8 | 32'h20 | 32'h80 | (1 << 8));
        wait_flag(1, seen);
        wr(REG_STAT, 2);
        rd(REG_CTRL, d); chk("R9 still enabled after wrap", {31'd0, d[0]}, 1);
        wait_flag(1, seen);
        chk("R9 second pass completes", {31'd0, seen}, 1);
        chk("R10 irq from complete flag", {31'd0, irq}, 1);
        rd(REG_REMAIN, d); chk("R12 remain readable in range", {31'd0, (d >= 1 && d <= 4)}, 1);
        wr(REG_SRC, 5);
        rd(REG_SRC, d);   chk("R12 source write ignored", d, SRC);
        wr(REG_COUNT, 9);
        rd(REG_COUNT, d); chk("R12 count write ignored", d, 4);
        wr(REG_CTRL, 32'h0 | (2 << 1) | 32'h8 | 32'h20 | 32'h80 | (1 << 8));
        repeat (8) @(negedge clk);
        s0 = we_cnt;
        repeat (20) @(negedge clk);
        chk("R12 stopped after disable", we_cnt - s0, 0);
        rd(REG_CTRL, d); chk("R12 enable cleared", {31'd0, d[0]}, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule